// File: doc/BRIEF.md
# Chained DMA descriptor sequencer

This block controls one DMA channel that moves data between a local bus and a remote backplane bus. Software either loads a single transfer into the channel registers and starts it (direct mode), or points the channel at a linked list of descriptors in memory and starts it in chained mode. In chained mode the block reads each descriptor through a simple memory read port and hands the decoded transfer to an external data mover. It then follows the link word to the next descriptor until it reaches a link with the end marker.

The block does not move any data itself. Each transfer is presented to the mover as a held request that carries direction, width, address space, access attributes, byte count and both addresses. The mover answers with a done pulse or with an error pulse. The block keeps sticky done and error flags that software clears by writing 1 to them. It also drives one interrupt line, which is the OR of every flag whose enable is set.

Register word index on `reg_addr`: 0 control word, 1 byte count, 2 local address, 3 remote address, 4 descriptor pointer, 5 channel status/control.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset every register reads 0, the channel is idle, `irq` is 0, and neither `mem_rd` nor `mv_req` is asserted.
- R2: In the status/control word, bit 31 written as 1 starts the channel and bit 27 selects chained mode. A direct start issues one mover request whose fields come from the registers. Control bit 31 gives the direction (1 = local to remote), bits 23:22 the width, bits 18:16 the space, bit 14 program access, bit 12 supervisor access and bit 8 block cycles. On done, status bit 11 (done) sets and bit 15 (active) clears.
- R3: A chained start reads seven words from the pointer with its low 4 bits cleared, at offsets 0, 4, 8 up to 24. The words arrive in the order control, count, local address, spare, remote address, spare, link.
- R4: After each completed descriptor the pointer register takes that descriptor's link. A link with bit 0 clear starts the next fetch, and a link with bit 0 set ends the chain and sets done. Done does not set before the last descriptor.
- R5: A descriptor is rejected without a mover request when any of these holds: the count is 0, the count is 2^24 or more, the local and remote address bits 2:0 differ, or the space code is 3, 4 or 5. A rejection sets the local error flag (bit 10) and clears active.
- R6: A mover error stops the channel at once. `mv_err` bits 2, 1 and 0 set status bits 10 (local), 9 (remote) and 8 (parity). Done is not set, and the pointer register keeps the address of the failing descriptor.
- R7: Writing 1 to any of status bits 11:8 clears that flag, and writing 0 leaves it unchanged.
- R8: When a flag is set by the hardware in the same cycle that software writes 1 to clear it, the flag ends up set.
- R9: Status bits 3, 2, 1 and 0 enable the interrupt for done, local, remote and parity. `irq` is 1 exactly when some enabled flag is set.
- R10: While the channel is active, a start, a change of the mode bit and writes to registers 0 to 4 are ignored.
- R11: `mem_rd` holds with a stable address until `mem_ack`. `mv_req` holds until `mv_done` or `mv_err`. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_rd | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read word accepted, `mem_rdata` valid |
| mem_rdata | input | 32 | Descriptor word |
| mv_req | output | 1 | Transfer request to the data mover |
| mv_dir | output | 1 | 1 = local to remote |
| mv_width | output | 2 | Remote data width code |
| mv_space | output | 3 | Remote address space code |
| mv_prog | output | 1 | Program access |
| mv_supv | output | 1 | Supervisor access |
| mv_block | output | 1 | Block-transfer cycles |
| mv_count | output | CNT_W | Byte count |
| mv_laddr | output | 32 | Local address |
| mv_raddr | output | 32 | Remote address |
| mv_done | input | 1 | Transfer finished |
| mv_err | input | 3 | Transfer error: local, remote, parity |
| irq | output | 1 | Interrupt |

## Verification
Two functions of the status word can land on the same clock edge. One is the hardware setting a flag when the mover finishes; the other is a software write that clears the same flag. The bench takes manual control of the mover, waits for the request and then pulses `mv_done` in the same cycle as a status write with bit 11 set. It reads done back as 1 with active clear. A second overlap is a start and register writes issued while a slow transfer is still active. The bench judges this from the mover seeing a single request and from the control word and mode bit reading back unchanged.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 7;
    localparam int DESC_IW    = $clog2(DESC_WORDS);
    localparam int NFLAG      = 4;

    typedef enum logic [2:0] {
        RA_CTL  = 3'd0,
        RA_CNT  = 3'd1,
        RA_LADR = 3'd2,
        RA_RADR = 3'd3,
        RA_NEXT = 3'd4,
        RA_GCS  = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MOVE
    } seq_state_e;

    // descriptor word slots that carry data (the others are spare)
    localparam logic [DESC_IW-1:0] DW_CTL  = 3'd0;
    localparam logic [DESC_IW-1:0] DW_CNT  = 3'd1;
    localparam logic [DESC_IW-1:0] DW_LADR = 3'd2;
    localparam logic [DESC_IW-1:0] DW_RADR = 3'd4;
    localparam logic [DESC_IW-1:0] DW_LINK = 3'd6;

    // status/control word
    localparam int G_START  = 31;
    localparam int G_CHAIN  = 27;
    localparam int G_ACTIVE = 15;
    localparam int G_FLAG_LO = 8;
    localparam int G_FLAG_HI = G_FLAG_LO + NFLAG - 1;

    // flag vector positions {done, local, remote, parity}
    localparam int F_DONE = 3;
    localparam int F_LERR = 2;

    // control word fields
    localparam int C_DIR    = 31;
    localparam int C_WID_LO = 22;
    localparam int C_SPC_LO = 16;
    localparam int C_PROG   = 14;
    localparam int C_SUPV   = 12;
    localparam int C_BLK    = 8;

    typedef struct packed {
        logic       dir;
        logic [1:0] width;
        logic [2:0] space;
        logic       prog;
        logic       supv;
        logic       blk;
    } xfer_attr_t;

    function automatic logic space_legal(input logic [2:0] s);
        return (s == 3'd0) || (s == 3'd1) || (s == 3'd2) || (s == 3'd6) || (s == 3'd7);
    endfunction

endpackage

// File: rtl/dseq_fetch.sv
module dseq_fetch
    import dseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [ADDR_W-5:0]   base_blk,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                word_vld,
    output logic [DESC_IW-1:0]  word_idx,
    output logic [WORD_W-1:0]   word_data,
    output logic                fin
);
    localparam logic [DESC_IW-1:0] LAST_IDX = DESC_IW'(DESC_WORDS - 1);

    logic                busy_q;
    logic [DESC_IW-1:0]  idx_q;
    logic [ADDR_W-5:0]   blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            blk_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            blk_q  <= base_blk;
        end else if (busy_q && mem_ack) begin
            if (idx_q == LAST_IDX) busy_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign mem_rd    = busy_q;
    assign mem_addr  = {blk_q, 4'b0000} + (ADDR_W'(idx_q) << 2);
    assign word_vld  = busy_q && mem_ack;
    assign word_idx  = idx_q;
    assign word_data = mem_rdata;
    assign fin       = word_vld && (idx_q == LAST_IDX);
endmodule

// File: rtl/dseq_status.sv
module dseq_status #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic          en_we,
    input  logic [NF-1:0] en_d,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] en,
    output logic          irq
);
    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst) f_q <= 1'b0;
            else     f_q <= set[gi] | (f_q & ~clr[gi]);
        end
        assign flags[gi] = f_q;
    end

    always_ff @(posedge clk) begin
        if (rst)        en <= '0;
        else if (en_we) en <= en_d;
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [31:0]         mem_rdata,
    output logic                mv_req,
    output logic                mv_dir,
    output logic [1:0]          mv_width,
    output logic [2:0]          mv_space,
    output logic                mv_prog,
    output logic                mv_supv,
    output logic                mv_block,
    output logic [CNT_W-1:0]    mv_count,
    output logic [31:0]         mv_laddr,
    output logic [31:0]         mv_raddr,
    input  logic                mv_done,
    input  logic [2:0]          mv_err,
    output logic                irq
);
    seq_state_e        state_q, state_n;
    logic [WORD_W-1:0] ctl_q, cnt_q, ladr_q, radr_q, nxt_q, link_q;
    logic              chain_q;
    logic              chan_active;

    logic              gcs_wr, host_wr, start_acc;
    logic              fetch_go;
    logic [ADDR_W-5:0] fetch_blk;
    logic              nxt_ld;
    logic [NFLAG-1:0]  fset, fclr, flags, en;
    logic              desc_ok;

    logic                word_vld, fin;
    logic [DESC_IW-1:0]  word_idx;
    logic [WORD_W-1:0]   word_data;
    xfer_attr_t          attr;

    assign chan_active = (state_q != ST_IDLE);
    assign gcs_wr      = reg_we && (reg_addr == RA_GCS);
    assign host_wr     = reg_we && !chan_active;
    assign start_acc   = gcs_wr && reg_wdata[G_START] && !chan_active;

    assign desc_ok = (cnt_q != '0)
                  && (cnt_q[WORD_W-1:CNT_W] == '0)
                  && (ladr_q[2:0] == radr_q[2:0])
                  && space_legal(ctl_q[C_SPC_LO +: 3]);

    always_comb begin
        state_n   = state_q;
        fetch_go  = 1'b0;
        fetch_blk = nxt_q[ADDR_W-1:4];
        fset      = '0;
        nxt_ld    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_acc) begin
                    if (reg_wdata[G_CHAIN]) begin
                        state_n  = ST_FETCH;
                        fetch_go = 1'b1;
                    end else begin
                        state_n = ST_CHECK;
                    end
                end
            end
            ST_FETCH: begin
                if (fin) state_n = ST_CHECK;
            end
            ST_CHECK: begin
                if (desc_ok) begin
                    state_n = ST_MOVE;
                end else begin
                    state_n      = ST_IDLE;
                    fset[F_LERR] = 1'b1;
                end
            end
            ST_MOVE: begin
                if (mv_err != '0) begin
                    state_n   = ST_IDLE;
                    fset[2:0] = mv_err;
                end else if (mv_done) begin
                    nxt_ld = chain_q;
                    if (chain_q && !link_q[0]) begin
                        state_n   = ST_FETCH;
                        fetch_go  = 1'b1;
                        fetch_blk = link_q[ADDR_W-1:4];
                    end else begin
                        state_n      = ST_IDLE;
                        fset[F_DONE] = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            cnt_q   <= '0;
            ladr_q  <= '0;
            radr_q  <= '0;
            nxt_q   <= '0;
            link_q  <= '0;
            chain_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (host_wr) begin
                case (reg_addr)
                    RA_CTL:  ctl_q   <= reg_wdata;
                    RA_CNT:  cnt_q   <= reg_wdata;
                    RA_LADR: ladr_q  <= reg_wdata;
                    RA_RADR: radr_q  <= reg_wdata;
                    RA_NEXT: nxt_q   <= reg_wdata;
                    RA_GCS:  chain_q <= reg_wdata[G_CHAIN];
                    default: ;
                endcase
            end
            if (word_vld) begin
                case (word_idx)
                    DW_CTL:  ctl_q  <= word_data;
                    DW_CNT:  cnt_q  <= word_data;
                    DW_LADR: ladr_q <= word_data;
                    DW_RADR: radr_q <= word_data;
                    DW_LINK: link_q <= word_data;
                    default: ;
                endcase
            end
            if (nxt_ld) nxt_q <= link_q;
        end
    end

    assign fclr = gcs_wr ? reg_wdata[G_FLAG_HI:G_FLAG_LO] : '0;

    dseq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (fetch_go),
        .base_blk  (fetch_blk),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .word_vld  (word_vld),
        .word_idx  (word_idx),
        .word_data (word_data),
        .fin       (fin)
    );

    dseq_status #(.NF(NFLAG)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set   (fset),
        .clr   (fclr),
        .en_we (gcs_wr),
        .en_d  (reg_wdata[NFLAG-1:0]),
        .flags (flags),
        .en    (en),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTL:  reg_rdata = ctl_q;
            RA_CNT:  reg_rdata = cnt_q;
            RA_LADR: reg_rdata = ladr_q;
            RA_RADR: reg_rdata = radr_q;
            RA_NEXT: reg_rdata = nxt_q;
            RA_GCS: begin
                reg_rdata[G_CHAIN]             = chain_q;
                reg_rdata[G_ACTIVE]            = chan_active;
                reg_rdata[G_FLAG_HI:G_FLAG_LO] = flags;
                reg_rdata[NFLAG-1:0]           = en;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign attr = '{dir:   ctl_q[C_DIR],
                    width: ctl_q[C_WID_LO +: 2],
                    space: ctl_q[C_SPC_LO +: 3],
                    prog:  ctl_q[C_PROG],
                    supv:  ctl_q[C_SUPV],
                    blk:   ctl_q[C_BLK]};

    assign mv_req   = (state_q == ST_MOVE);
    assign mv_dir   = attr.dir;
    assign mv_width = attr.width;
    assign mv_space = attr.space;
    assign mv_prog  = attr.prog;
    assign mv_supv  = attr.supv;
    assign mv_block = attr.blk;
    assign mv_count = cnt_q[CNT_W-1:0];
    assign mv_laddr = ladr_q;
    assign mv_raddr = radr_q;
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mv_req,
    input logic              mv_done,
    input logic [2:0]        mv_err,
    input logic [CNT_W-1:0]  mv_count,
    input logic [31:0]       mv_laddr,
    input logic [31:0]       mv_raddr,
    input logic              chan_active
);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));

    // R3
    mem_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> mem_addr[1:0] == 2'b00);

    // R11
    mv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mv_req && !mv_done && (mv_err == 3'b000) |=> mv_req);

    // R5
    mv_legal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mv_req) |-> (mv_count != '0) && (mv_laddr[2:0] == mv_raddr[2:0]));

    // R6
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        mv_req && (mv_err != 3'b000) |=> !chan_active && !mv_req);

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mv_req));
endmodule

bind dma_chain_seq dseq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_rd      (mem_rd),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mv_req      (mv_req),
    .mv_done     (mv_done),
    .mv_err      (mv_err),
    .mv_count    (mv_count),
    .mv_laddr    (mv_laddr),
    .mv_raddr    (mv_raddr),
    .chan_active (chan_active)
);

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_rd, mem_ack = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic mv_req, mv_dir, mv_prog, mv_supv, mv_block;
    logic [1:0] mv_width;
    logic [2:0] mv_space;
    logic [CNT_W-1:0] mv_count;
    logic [31:0] mv_laddr, mv_raddr;
    logic mv_done = 1'b0;
    logic [2:0] mv_err = 3'b000;
    logic irq;

    always #10 clk = ~clk;

    dma_chain_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_dir(mv_dir), .mv_width(mv_width),
        .mv_space(mv_space), .mv_prog(mv_prog), .mv_supv(mv_supv),
        .mv_block(mv_block), .mv_count(mv_count), .mv_laddr(mv_laddr),
        .mv_raddr(mv_raddr), .mv_done(mv_done), .mv_err(mv_err), .irq(irq)
    );

    localparam logic [2:0] A_CTL = 3'd0, A_CNT = 3'd1, A_LADR = 3'd2,
                           A_RADR = 3'd3, A_NEXT = 3'd4, A_GCS = 3'd5;

    int n_chk = 0;
    int n_fail = 0;

    // models
    logic [31:0] mem [64];
    logic [31:0] fa_log [32];
    int          fa_n = 0;
    logic [2:0]  mv_plan [8];
    int          mv_n = 0;
    int          mv_wait = 0;
    int          mv_delay = 2;
    bit          mv_manual = 0;
    logic [8:0]  seen_attr [8];
    logic [23:0] seen_cnt [8];
    logic [31:0] seen_ladr [8];
    logic [31:0] seen_radr [8];
    logic        seen_irq [8];

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] cnt;
        logic [31:0] ladr;
        logic [31:0] radr;
        logic [2:0]  resp;
        logic [3:0]  flags;
        logic        req;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h8082_5100, 32'h0000_0100, 32'h0000_1000, 32'h0000_2000, 3'b000, 4'b1000, 1'b1},
        '{32'h0041_0000, 32'h00FF_FFFF, 32'h0000_0013, 32'h0005_0003, 3'b000, 4'b1000, 1'b1},
        '{32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'b000, 4'b0100, 1'b0},
        '{32'h8000_0000, 32'h0100_0000, 32'h0000_0000, 32'h0000_0000, 3'b000, 4'b0100, 1'b0},
        '{32'h8000_0000, 32'h0000_0010, 32'h0000_0004, 32'h0000_0005, 3'b000, 4'b0100, 1'b0},
        '{32'h0003_0000, 32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 3'b000, 4'b0100, 1'b0},
        '{32'h00C7_1000, 32'h0000_0020, 32'h0000_0008, 32'h0000_0010, 3'b010, 4'b0010, 1'b1},
        '{32'h8006_4100, 32'h0000_0004, 32'h0000_0001, 32'h0000_0009, 3'b001, 4'b0001, 1'b1},
        '{32'h0002_0000, 32'h0000_0040, 32'h0000_0000, 32'h0000_0000, 3'b100, 4'b0100, 1'b1}
    };

    function automatic logic [8:0] attr_of(input logic [31:0] c);
        return {c[31], c[23:22], c[18:16], c[14], c[12], c[8]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        mem_ack   = mem_rd;
        mem_rdata = mem_rd ? mem[mem_addr[7:2]] : 32'h0;
        if (mem_rd) begin
            if (fa_n < 32) fa_log[fa_n] = mem_addr;
            fa_n++;
        end
        if (mv_done || mv_err != 3'b000) begin
            mv_done = 1'b0;
            mv_err  = 3'b000;
        end else if (mv_req && !mv_manual) begin
            if (mv_wait >= mv_delay) begin
                seen_attr[mv_n[2:0]] = {mv_dir, mv_width, mv_space, mv_prog, mv_supv, mv_block};
                seen_cnt[mv_n[2:0]]  = mv_count;
                seen_ladr[mv_n[2:0]] = mv_laddr;
                seen_radr[mv_n[2:0]] = mv_raddr;
                seen_irq[mv_n[2:0]]  = irq;
                if (mv_plan[mv_n[2:0]] == 3'b000) mv_done = 1'b1;
                else                               mv_err  = mv_plan[mv_n[2:0]];
                mv_n++;
                mv_wait = 0;
            end else begin
                mv_wait++;
            end
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] g;
        for (int i = 0; i < 2000; i++) begin
            rd(A_GCS, g);
            if (!g[15]) break;
            tick();
        end
    endtask

    task automatic put_desc(input int w, input logic [31:0] c, input logic [31:0] n,
                            input logic [31:0] la, input logic [31:0] ra, input logic [31:0] lk);
        mem[w] = c; mem[w+1] = n; mem[w+2] = la; mem[w+3] = 32'hDEAD_0001;
        mem[w+4] = ra; mem[w+5] = 32'hDEAD_0002; mem[w+6] = lk;
    endtask

    task automatic reset_models();
        fa_n = 0; mv_n = 0; mv_wait = 0;
        for (int i = 0; i < 8; i++) mv_plan[i] = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] g;
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        reset_models();
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, "R1 reg after reset", v, 32'h0);
        end
        chk(!irq && !mv_req && !mem_rd, "R1 outputs idle", {irq, mv_req, mem_rd}, 32'h0);

        // table of direct transfers: R2, R5, R6
        for (int k = 0; k < 9; k++) begin
            reset_models();
            mv_plan[0] = VECS[k].resp;
            wr(A_GCS, 32'h0000_0F00);
            wr(A_CTL, VECS[k].ctl);
            wr(A_CNT, VECS[k].cnt);
            wr(A_LADR, VECS[k].ladr);
            wr(A_RADR, VECS[k].radr);
            wr(A_GCS, 32'h8000_0000);
            wait_idle();
            rd(A_GCS, g);
            if (!VECS[k].req)
                chk(g[11:8] == VECS[k].flags && mv_n == 0, "R5 rejected descriptor", {g[11:8], 4'(mv_n)}, {VECS[k].flags, 4'h0});
            else if (VECS[k].resp != 0)
                chk(g[11:8] == VECS[k].flags && !g[15], "R6 mover error flags", g, {20'h0, VECS[k].flags, 8'h0});
            else
                chk(g[11:8] == VECS[k].flags && !g[15], "R2 direct done", g, {20'h0, VECS[k].flags, 8'h0});
            if (VECS[k].req) begin
                chk(mv_n == 1, "R2 one request", mv_n, 1);
                chk(seen_attr[0] == attr_of(VECS[k].ctl), "R2 attribute decode", seen_attr[0], attr_of(VECS[k].ctl));
                chk(seen_cnt[0] == VECS[k].cnt[23:0] && seen_ladr[0] == VECS[k].ladr && seen_radr[0] == VECS[k].radr,
                    "R2 count and addresses", seen_ladr[0], VECS[k].ladr);
            end
        end

        // R3, R4: three-descriptor chain
        put_desc(16, 32'h8082_0000, 32'h10, 32'h100, 32'h200, 32'h0000_008A);
        put_desc(32, 32'h0000_0000, 32'h08, 32'h011, 32'h031, 32'h0000_00C0);
        put_desc(48, 32'h0001_0100, 32'h04, 32'h008, 32'h010, 32'h0000_0001);
        reset_models();
        wr(A_GCS, 32'h0000_0F08);
        wr(A_NEXT, 32'h0000_0046);
        wr(A_GCS, 32'h8800_0008);
        wait_idle();
        chk(mv_n == 3, "R4 three transfers", mv_n, 3);
        chk(fa_n == 21, "R3 word reads", fa_n, 21);
        for (int i = 0; i < 21; i++) begin
            v = 32'h40 * (i / 7 + 1) + 4 * (i % 7);
            if (fa_log[i] != v) chk(0, "R3 fetch address order", fa_log[i], v);
        end
        chk(fa_log[20] == 32'hD8, "R3 last link word address", fa_log[20], 32'hD8);
        chk(seen_ladr[0] == 32'h100 && seen_ladr[1] == 32'h11 && seen_ladr[2] == 32'h8,
            "R4 chain local addresses", seen_ladr[1], 32'h11);
        chk(seen_attr[1] == 9'h0 && seen_attr[2] == attr_of(32'h0001_0100), "R4 per-descriptor control", seen_attr[2], attr_of(32'h0001_0100));
        chk(!seen_irq[0] && !seen_irq[1], "R4 no done before end", {seen_irq[0], seen_irq[1]}, 0);
        rd(A_NEXT, v);
        chk(v == 32'h1, "R4 pointer holds end link", v, 32'h1);
        rd(A_GCS, g);
        chk(g[11:8] == 4'b1000 && irq, "R9 done irq at chain end", g, 32'h0800_0808);

        // R6: invalid second descriptor, pointer stays there
        mem[33] = 32'h0;
        reset_models();
        wr(A_GCS, 32'h0000_0F00);
        wr(A_NEXT, 32'h0000_0046);
        wr(A_GCS, 32'h8800_0000);
        wait_idle();
        rd(A_NEXT, v);
        rd(A_GCS, g);
        chk(v == 32'h8A && g[11:8] == 4'b0100 && mv_n == 1, "R6 stop on bad descriptor", v, 32'h8A);

        // R6: mover remote error on first descriptor
        mem[33] = 32'h08;
        reset_models();
        mv_plan[0] = 3'b010;
        wr(A_GCS, 32'h0000_0F00);
        wr(A_NEXT, 32'h0000_0046);
        wr(A_GCS, 32'h8800_0000);
        wait_idle();
        rd(A_NEXT, v);
        rd(A_GCS, g);
        chk(v == 32'h46 && g[11:8] == 4'b0010 && mv_n == 1 && fa_n == 7, "R6 pointer on failing descriptor", v, 32'h46);

        // R9: enables
        wr(A_GCS, 32'h0000_0002);
        chk(irq == 1'b1, "R9 remote enable", irq, 1);
        wr(A_GCS, 32'h0000_0005);
        chk(irq == 1'b0, "R9 other enables", irq, 0);

        // R7: write-one-to-clear
        wr(A_GCS, 32'h0000_0D00);
        rd(A_GCS, g);
        chk(g[11:8] == 4'b0010, "R7 zero leaves flag", g[11:8], 4'b0010);
        wr(A_GCS, 32'h0000_0200);
        rd(A_GCS, g);
        chk(g[11:8] == 4'b0000, "R7 one clears flag", g[11:8], 0);

        // R10: start and writes ignored while active
        reset_models();
        mv_delay = 12;
        wr(A_CTL, 32'h0002_0000);
        wr(A_CNT, 32'h40);
        wr(A_LADR, 32'h0);
        wr(A_RADR, 32'h0);
        wr(A_GCS, 32'h8000_0000);
        wr(A_CTL, 32'hFFFF_FFFF);
        wr(A_GCS, 32'h8800_0000);
        wait_idle();
        rd(A_CTL, v);
        chk(v == 32'h0002_0000, "R10 control write ignored", v, 32'h0002_0000);
        rd(A_GCS, g);
        chk(!g[27] && g[11:8] == 4'b1000 && mv_n == 1, "R10 start ignored", g, 32'h0000_0800);
        mv_delay = 2;

        // R8: hardware set wins over same-cycle clear
        reset_models();
        mv_manual = 1;
        wr(A_GCS, 32'h0000_0F00);
        wr(A_GCS, 32'h8000_0000);
        for (int i = 0; i < 20; i++) begin
            if (mv_req) break;
            tick();
        end
        mv_done = 1'b1;
        reg_we = 1'b1; reg_addr = A_GCS; reg_wdata = 32'h0000_0800;
        tick();
        reg_we = 1'b0;
        mv_manual = 0;
        rd(A_GCS, g);
        chk(g[11] && !g[15], "R8 set beats clear", g, 32'h0000_0800);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule